// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

This block sits between an SDRAM command scheduler and the memory command pins. The scheduler offers one command at a time: activate, read, write or precharge, with a bank index. The guard keeps a set of minimum-spacing windows for each bank and one window shared by all banks. It grants the command only when every window that applies to it has run out. The granted command is driven on the issue outputs in the same cycle. A command that is not yet legal stays pending, and the scheduler holds it stable until it is granted.

All spacing values are whole clock-cycle counts taken from 4-bit configuration inputs. A programmed value N lets the dependent command go N+1 cycles after the command that opened the window, so a value of zero means the next cycle. The guard also tracks whether each bank is open or closed. A command that contradicts that state gets a one-cycle error pulse and is never issued. The scheduler then drops that command. The longest time a bank may stay open is deliberately not checked, because the controller always closes a bank after use.

Top module: `sdram_timing_guard`

## Requirements
- R1: A synchronous active-high reset clears every window and marks all banks closed. With no request offered, the grant, error and issue-valid outputs are low and the issue command reads 0.
- R2: After a precharge to bank b is issued in cycle t, an activate to bank b is not granted before cycle t+cfgPrechargeGap+1.
- R3: After an activate to bank b is issued in cycle t, a precharge to bank b is not granted before cycle t+cfgOpenMin+1. This also holds at the largest value, 15.
- R4: After an activate to bank b is issued in cycle t, a read or write to bank b is not granted before cycle t+cfgActToCol+1.
- R5: After any activate is issued in cycle t, no activate to any bank is granted before cycle t+cfgActToAct+1.
- R6: After an activate to bank b is issued in cycle t, another activate to bank b is not granted before cycle t+cfgRowCycle+1, even when the precharge window has already run out.
- R7: Command codes are NOP=0, ACT=1, READ=2, WRITE=3, PRE=4. A legal request has reqGrant low while it waits, and is granted in the first cycle in which all of its windows have run out. In the grant cycle, issueValid is 1 and issueCmd and issueBank equal the request. In every other cycle, issueValid is 0 and issueCmd is 0.
- R8: A read or write to a closed bank, or an activate to an open bank, raises reqError for the cycle in which it is offered. It is not granted and it leaves the bank's state unchanged.
- R9: The windows of one bank never delay a read, write or precharge to another bank. A precharge to a closed bank is granted once that bank's open window has run out, and it restarts that bank's precharge window.
- R10: Codes 5 to 7 are neither granted nor flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A command is offered |
| reqCmd | input | 3 | Offered command code |
| reqBank | input | 2 | Offered bank index |
| cfgPrechargeGap | input | 4 | Precharge-to-activate spacing, same bank |
| cfgOpenMin | input | 4 | Activate-to-precharge spacing, same bank |
| cfgActToCol | input | 4 | Activate-to-read/write spacing, same bank |
| cfgActToAct | input | 4 | Activate-to-activate spacing, any banks |
| cfgRowCycle | input | 4 | Activate-to-activate spacing, same bank |
| reqGrant | output | 1 | Offered command is issued this cycle |
| reqError | output | 1 | Offered command contradicts the bank state |
| issueValid | output | 1 | A command is driven to the memory |
| issueCmd | output | 3 | Issued command code |
| issueBank | output | 2 | Issued bank index |

## Verification
The hardest case to reach is one where the same-bank row-cycle window is the only thing holding an activate back. To get there, a bench must close the bank quickly with a short open window and a zero precharge gap. It must then offer the activate again while the longer row-cycle count is still running. The stimulus sets those values after a reset and issues activate, precharge and activate back to back, so the wait that results can only come from R6. A second sequence loads the largest open window into one bank and then works on a different bank. This shows that the two banks' windows are kept apart.

// File: rtl/sdtg_pkg.sv
package sdtg_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_PRE   = 3'd4
  } cmd_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic actStb;
    logic preStb;
  } strobe_t;

endpackage

// File: rtl/sdtg_downcnt.sv
module sdtg_downcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= loadVal;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sdtg_bank_timers.sv
module sdtg_bank_timers
  import sdtg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TW        = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              stb,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic [TW-1:0]        cfgPrechargeGap,
  input  logic [TW-1:0]        cfgOpenMin,
  input  logic [TW-1:0]        cfgActToCol,
  input  logic [TW-1:0]        cfgActToAct,
  input  logic [TW-1:0]        cfgRowCycle,
  output logic [NUM_BANKS-1:0] rpDone,
  output logic [NUM_BANKS-1:0] rasDone,
  output logic [NUM_BANKS-1:0] rcdDone,
  output logic [NUM_BANKS-1:0] rcDone,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 rrdDone
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit, actHere, preHere;
    assign hit     = (bankSel == BANK_W'(b));
    assign actHere = stb.actStb && hit;
    assign preHere = stb.preStb && hit;

    sdtg_downcnt #(.W(TW)) u_rp  (.clk(clk), .rst(rst), .load(preHere),
                                  .loadVal(cfgPrechargeGap), .expired(rpDone[b]));
    sdtg_downcnt #(.W(TW)) u_ras (.clk(clk), .rst(rst), .load(actHere),
                                  .loadVal(cfgOpenMin), .expired(rasDone[b]));
    sdtg_downcnt #(.W(TW)) u_rcd (.clk(clk), .rst(rst), .load(actHere),
                                  .loadVal(cfgActToCol), .expired(rcdDone[b]));
    sdtg_downcnt #(.W(TW)) u_rc  (.clk(clk), .rst(rst), .load(actHere),
                                  .loadVal(cfgRowCycle), .expired(rcDone[b]));

    always_ff @(posedge clk) begin
      if (rst)          bankOpen[b] <= 1'b0;
      else if (actHere) bankOpen[b] <= 1'b1;
      else if (preHere) bankOpen[b] <= 1'b0;
    end
  end

  sdtg_downcnt #(.W(TW)) u_rrd (.clk(clk), .rst(rst), .load(stb.actStb),
                                .loadVal(cfgActToAct), .expired(rrdDone));
endmodule

// File: rtl/sdtg_guard_ctrl.sv
module sdtg_guard_ctrl
  import sdtg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 reqValid,
  input  logic [2:0]           reqCmd,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [NUM_BANKS-1:0] rpDone,
  input  logic [NUM_BANKS-1:0] rasDone,
  input  logic [NUM_BANKS-1:0] rcdDone,
  input  logic [NUM_BANKS-1:0] rcDone,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 rrdDone,
  output logic                 reqGrant,
  output logic                 reqError,
  output strobe_t              stb,
  output logic                 issueValid,
  output logic [2:0]           issueCmd,
  output logic [BANK_W-1:0]    issueBank
);
  logic ready, clash, known;

  always_comb begin
    ready = 1'b0;
    clash = 1'b0;
    known = 1'b1;
    case (reqCmd)
      CMD_ACT: begin
        clash = bankOpen[reqBank];
        ready = rpDone[reqBank] && rcDone[reqBank] && rrdDone;
      end
      CMD_READ, CMD_WRITE: begin
        clash = !bankOpen[reqBank];
        ready = rcdDone[reqBank];
      end
      CMD_PRE: ready = rasDone[reqBank];
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    reqError   = reqValid && known && clash;
    reqGrant   = reqValid && known && !clash && ready;
    stb.actStb = reqGrant && (reqCmd == CMD_ACT);
    stb.preStb = reqGrant && (reqCmd == CMD_PRE);
    issueValid = reqGrant;
    issueCmd   = reqGrant ? reqCmd  : CMD_NOP;
    issueBank  = reqGrant ? reqBank : '0;
  end
endmodule

// File: rtl/sdram_timing_guard.sv
module sdram_timing_guard
  import sdtg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TW        = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [2:0]        reqCmd,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [TW-1:0]     cfgPrechargeGap,
  input  logic [TW-1:0]     cfgOpenMin,
  input  logic [TW-1:0]     cfgActToCol,
  input  logic [TW-1:0]     cfgActToAct,
  input  logic [TW-1:0]     cfgRowCycle,
  output logic              reqGrant,
  output logic              reqError,
  output logic              issueValid,
  output logic [2:0]        issueCmd,
  output logic [BANK_W-1:0] issueBank
);
  strobe_t              stb;
  logic [NUM_BANKS-1:0] rpDone, rasDone, rcdDone, rcDone, bankOpen;
  logic                 rrdDone;

  sdtg_guard_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .reqValid(reqValid), .reqCmd(reqCmd), .reqBank(reqBank),
    .rpDone(rpDone), .rasDone(rasDone), .rcdDone(rcdDone), .rcDone(rcDone),
    .bankOpen(bankOpen), .rrdDone(rrdDone),
    .reqGrant(reqGrant), .reqError(reqError), .stb(stb),
    .issueValid(issueValid), .issueCmd(issueCmd), .issueBank(issueBank));

  sdtg_bank_timers #(.NUM_BANKS(NUM_BANKS), .TW(TW)) u_timers (
    .clk(clk), .rst(rst), .stb(stb), .bankSel(reqBank),
    .cfgPrechargeGap(cfgPrechargeGap), .cfgOpenMin(cfgOpenMin),
    .cfgActToCol(cfgActToCol), .cfgActToAct(cfgActToAct),
    .cfgRowCycle(cfgRowCycle),
    .rpDone(rpDone), .rasDone(rasDone), .rcdDone(rcdDone), .rcDone(rcDone),
    .bankOpen(bankOpen), .rrdDone(rrdDone));
endmodule

// File: rtl/sdtg_checker.sv
module sdtg_checker #(
  parameter int NUM_BANKS = 4,
  parameter int TW        = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [2:0]        reqCmd,
  input logic [BANK_W-1:0] reqBank,
  input logic [TW-1:0]     cfgPrechargeGap,
  input logic [TW-1:0]     cfgOpenMin,
  input logic [TW-1:0]     cfgActToCol,
  input logic [TW-1:0]     cfgActToAct,
  input logic              reqGrant,
  input logic              reqError,
  input logic              issueValid,
  input logic [2:0]        issueCmd,
  input logic [BANK_W-1:0] issueBank
);
  logic actIss, preIss, colIss;
  assign actIss = issueValid && issueCmd == 3'd1;
  assign preIss = issueValid && issueCmd == 3'd4;
  assign colIss = issueValid && (issueCmd == 3'd2 || issueCmd == 3'd3);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !reqValid |-> (!reqGrant && !reqError && !issueValid));

  a_r2_rp_gap: assert property (@(posedge clk) disable iff (rst)
    preIss |=> !(actIss && issueBank == $past(issueBank) && $past(cfgPrechargeGap) != '0));

  a_r3_ras_gap: assert property (@(posedge clk) disable iff (rst)
    actIss |=> !(preIss && issueBank == $past(issueBank) && $past(cfgOpenMin) != '0));

  a_r4_rcd_gap: assert property (@(posedge clk) disable iff (rst)
    actIss |=> !(colIss && issueBank == $past(issueBank) && $past(cfgActToCol) != '0));

  a_r5_rrd_gap: assert property (@(posedge clk) disable iff (rst)
    actIss |=> !(actIss && $past(cfgActToAct) != '0));

  a_r7_issue_mirrors: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> (reqValid && reqGrant && issueCmd == reqCmd && issueBank == reqBank));

  a_r8_error_blocks: assert property (@(posedge clk) disable iff (rst)
    reqError |-> (!reqGrant && !issueValid));

  a_r10_unknown_code: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqCmd > 3'd4) |-> (!reqGrant && !reqError));
endmodule

bind sdram_timing_guard sdtg_checker #(.NUM_BANKS(NUM_BANKS), .TW(TW)) u_chk (.*);

// File: tb/test_sdram_timing_guard.sv
`timescale 1ns/100ps
module test_sdram_timing_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqValid = 1'b0;
  logic [2:0] reqCmd = 3'd0;
  logic [1:0] reqBank = 2'd0;
  logic [3:0] cfgPrechargeGap = 4'd0, cfgOpenMin = 4'd0, cfgActToCol = 4'd0;
  logic [3:0] cfgActToAct = 4'd0, cfgRowCycle = 4'd0;
  logic       reqGrant, reqError, issueValid;
  logic [2:0] issueCmd;
  logic [1:0] issueBank;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  sdram_timing_guard i_sdram_timing_guard (.*);

  localparam logic [2:0] ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  // vector: cmd[13:11] bank[10:9] expErr[8] expWait[7:4] reqTag[3:0]
  localparam int NV = 15;
  localparam logic [13:0] VECS [NV] = '{
    {ACT, 2'd0, 1'b0, 4'd0, 4'd1},  // R1 fresh bank
    {RD,  2'd0, 1'b0, 4'd1, 4'd4},  // R4
    {WR,  2'd0, 1'b0, 4'd0, 4'd4},  // R4
    {ACT, 2'd1, 1'b0, 4'd0, 4'd5},  // R5 window expired
    {ACT, 2'd2, 1'b0, 4'd1, 4'd5},  // R5 waits
    {PRE, 2'd0, 1'b0, 4'd0, 4'd3},  // R3 window expired
    {ACT, 2'd0, 1'b0, 4'd2, 4'd2},  // R2 waits
    {RD,  2'd3, 1'b1, 4'd0, 4'd8},  // R8 closed bank
    {ACT, 2'd1, 1'b1, 4'd0, 4'd8},  // R8 open bank
    {RD,  2'd1, 1'b0, 4'd0, 4'd8},  // R8 state kept
    {PRE, 2'd1, 1'b0, 4'd0, 4'd3},  // R3
    {RD,  2'd1, 1'b1, 4'd0, 4'd8},  // R8 after close
    {PRE, 2'd3, 1'b0, 4'd0, 4'd9},  // R9 closed bank
    {ACT, 2'd3, 1'b0, 4'd2, 4'd2},  // R2 restarted window
    {RD,  2'd0, 1'b0, 4'd0, 4'd7}   // R7
  };

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic setCfg(input logic [3:0] rp, ras, rcd, rrd, rc);
    cfgPrechargeGap = rp; cfgOpenMin = ras; cfgActToCol = rcd;
    cfgActToAct = rrd; cfgRowCycle = rc;
  endtask

  // offer one command and measure cycles until grant or error
  task automatic runReq(input logic [2:0] cmd, input logic [1:0] bank,
                        input bit expErr, input int expWait, input string tag);
    bit done = 0, gotErr = 0, badIssue = 0;
    int waited = 0;
    @(negedge clk);
    reqValid = 1'b1; reqCmd = cmd; reqBank = bank;
    while (!done && waited < 40) begin
      #1;
      if (reqError) begin
        gotErr = 1; done = 1;
        if (issueValid || reqGrant) badIssue = 1;
      end else if (reqGrant) begin
        done = 1;
        if (!issueValid || issueCmd != cmd || issueBank != bank) badIssue = 1;
      end else begin
        if (issueValid || issueCmd != 3'd0) badIssue = 1;
        waited++;
        @(negedge clk);
      end
    end
    check(done && gotErr == expErr && waited == expWait && !badIssue, tag,
          $sformatf("cmd %0d bank %0d err %0d wait %0d badIssue %0d, expected err %0d wait %0d",
                    cmd, bank, gotErr, waited, badIssue, expErr, expWait));
  endtask

  task automatic dropReq();
    @(negedge clk);
    reqValid = 1'b0; reqCmd = 3'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    finishRun();
  end

  initial begin
    // R1 reset state
    doReset();
    #1;
    check(!reqGrant && !reqError && !issueValid && issueCmd == 3'd0, "R1",
          $sformatf("idle outputs grant %0d err %0d valid %0d cmd %0d, expected 0 0 0 0",
                    reqGrant, reqError, issueValid, issueCmd));

    // table walk: rp 2, ras 4, rcd 1, rrd 1, rc 6
    setCfg(4'd2, 4'd4, 4'd1, 4'd1, 4'd6);
    for (int i = 0; i < NV; i++) begin
      runReq(VECS[i][13:11], VECS[i][10:9], VECS[i][8], int'(VECS[i][7:4]),
             $sformatf("R%0d vec %0d", VECS[i][3:0], i));
    end
    dropReq();

    // R6: row-cycle window alone holds the re-activate
    doReset();
    setCfg(4'd0, 4'd0, 4'd0, 4'd0, 4'd5);
    runReq(ACT, 2'd0, 0, 0, "R6 first act");
    runReq(PRE, 2'd0, 0, 0, "R6 quick close");
    runReq(ACT, 2'd0, 0, 4, "R6 row cycle wait");
    runReq(ACT, 2'd1, 0, 0, "R6 other bank free");
    dropReq();

    // R9 and R3 at max value: other bank unaffected
    doReset();
    setCfg(4'd0, 4'd15, 4'd0, 4'd0, 4'd0);
    runReq(ACT, 2'd0, 0, 0, "R9 act b0");
    runReq(ACT, 2'd1, 0, 0, "R9 act b1");
    runReq(RD,  2'd1, 0, 0, "R9 read b1 free");
    runReq(PRE, 2'd0, 0, 13, "R3 max open window");
    runReq(PRE, 2'd1, 0, 0, "R9 b1 window own");
    dropReq();

    // R1 reset mid-window clears counters and open state
    setCfg(4'd0, 4'd15, 4'd0, 4'd0, 4'd0);
    runReq(ACT, 2'd2, 0, 0, "R1 pre-reset act");
    doReset();
    #1;
    check(!reqGrant && !reqError && !issueValid, "R1",
          $sformatf("after reset grant %0d err %0d valid %0d, expected 0 0 0",
                    reqGrant, reqError, issueValid));
    runReq(RD,  2'd2, 1, 0, "R1 bank closed by reset");
    runReq(PRE, 2'd2, 0, 0, "R1 open window cleared");
    runReq(ACT, 2'd2, 0, 0, "R1 reactivate");
    dropReq();

    // R10 unknown code: never granted nor flagged
    begin
      bit bad = 0;
      @(negedge clk);
      reqValid = 1'b1; reqCmd = 3'd5; reqBank = 2'd0;
      for (int c = 0; c < 3; c++) begin
        #1;
        if (reqGrant || reqError || issueValid) bad = 1;
        @(negedge clk);
      end
      check(!bad, "R10", $sformatf("code 5 bad %0d, expected 0", bad));
      reqValid = 1'b0; reqCmd = 3'd0;
    end

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule